// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It watches the register indices and the write and load flags of the instructions in decode, execute, memory and writeback. It also watches a branch-taken signal from execute. From these it drives three kinds of output. Operand forwarding selects steer the two ALU inputs. A front-end hold freezes the program counter and the fetch/decode register. Flush strobes turn younger in-flight instructions into no-ops.

The block also holds the integer register file. The file has two read ports and one write port. A writeback that lands in the same cycle as a decode-stage read of the same register is passed straight through to that read port. The surrounding pipeline uses the outputs as plain enables and mux selects. The ALU, the memories, prediction and exceptions live elsewhere.

Top module: `hazard_unit`

## Requirements
- R1: Register 0 reads as zero on both read ports, even when a writeback targets it.
- R2: When writeback writes register r (r not 0) and a read port addresses r in the same cycle, that port returns the writeback data (write-first bypass). This holds on both ports.
- R3: A register written by writeback keeps its value and is returned on either read port in later cycles. The two read ports and the write port operate independently.
- R4: Each forward select (fwdSelA for the execute rs1, fwdSelB for rs2) is 2'b01 when the memory-stage instruction writes that source register. Otherwise it is 2'b10 when the writeback-stage instruction writes it. Otherwise it is 2'b00 (register file). A producer forwards only when its register-write flag is 1, and the memory stage wins over writeback.
- R5: A source register index of 0 always gives select 2'b00, whatever the producers hold.
- R6: When the execute instruction is a load (load and register-write flags set, destination not 0) and the decode instruction uses that register as a source, pcWrEn and fdWrEn go low and dxFlush goes high in that cycle. Once the load has moved on, the hold ends, so one load-use pair costs exactly one stall cycle.
- R7: No stall arises from a decode source field marked unused, from a load whose destination is register 0, or from a non-load producer.
- R8: A taken branch drives fdFlush and dxFlush high and suppresses any load-use stall in that cycle. A not-taken branch drives neither flush.
- R9: Right after reset, every register reads zero, both selects are 2'b00, both write enables are high and both flushes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| decRs1 | input | 5 | Decode-stage source 1 index |
| decRs2 | input | 5 | Decode-stage source 2 index |
| decUseRs1 | input | 1 | Decode instruction reads source 1 |
| decUseRs2 | input | 1 | Decode instruction reads source 2 |
| exRs1 | input | 5 | Execute-stage source 1 index |
| exRs2 | input | 5 | Execute-stage source 2 index |
| exRd | input | 5 | Execute-stage destination index |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| memRd | input | 5 | Memory-stage destination index |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | 5 | Writeback destination index |
| wbRegWrite | input | 1 | Writeback instruction writes a register |
| wbData | input | 32 | Writeback data |
| branchTaken | input | 1 | Execute-stage branch resolved taken |
| rdData1 | output | 32 | Register file read port 1 (decRs1) |
| rdData2 | output | 32 | Register file read port 2 (decRs2) |
| fwdSelA | output | 2 | ALU input A source select |
| fwdSelB | output | 2 | ALU input B source select |
| pcWrEn | output | 1 | Program counter write enable |
| fdWrEn | output | 1 | Fetch/decode register write enable |
| fdFlush | output | 1 | Squash the fetch/decode instruction |
| dxFlush | output | 1 | Clear the flags entering execute (bubble) |

## Verification
Some properties are checked on every cycle. These are the zero register on both ports, the same-cycle bypass, retention of a written value into the next cycle, the memory-over-writeback priority, the rule that a zero source never forwards, and the rule that a hold always comes with a bubble and never with a branch squash. Other behaviour shows only across instruction sequences, so the bench's scenarios must show it. These are the single-cycle length of a load-use stall as a load moves from execute to memory, back-to-back writes to one register, and the correct select once the stalled consumer reaches execute.

// File: rtl/hazard_pkg.sv
`timescale 1ns/1ps
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic holdFront;  // freeze PC and fetch/decode register
    logic bubbleEx;   // clear flags of instruction entering execute
    logic squashFd;   // turn fetch/decode instruction into a no-op
  } ctrlStrobes_t;
endpackage

// File: rtl/hazard_regfile.sv
`timescale 1ns/1ps
module hazard_regfile #(
  parameter int XLEN = 32,
  parameter int AW   = 5,
  parameter int NRD  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [AW-1:0]       wrAddr,
  input  logic [XLEN-1:0]     wrData,
  input  logic [NRD*AW-1:0]   rdAddr,
  output logic [NRD*XLEN-1:0] rdData
);
  localparam int NREG = 1 << AW;

  logic [XLEN-1:0] regs [NREG];
  logic            wrLive;

  assign wrLive = wrEn && (wrAddr != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wrLive) begin
      regs[wrAddr] <= wrData;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : gRead
    logic [AW-1:0] addr;
    assign addr = rdAddr[g*AW +: AW];
    assign rdData[g*XLEN +: XLEN] =
      (addr == '0)                ? '0     :
      (wrLive && wrAddr == addr)  ? wrData : regs[addr];

    // R1
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
      (addr == '0) |-> (rdData[g*XLEN +: XLEN] == '0));
    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr != '0 && wrAddr == addr) |-> (rdData[g*XLEN +: XLEN] == wrData));
  end

  // R3
  retain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0) |=>
      (!(rdAddr[AW-1:0] == $past(wrAddr) && !(wrEn && wrAddr == rdAddr[AW-1:0]))
       || rdData[XLEN-1:0] == $past(wrData)));
endmodule

// File: rtl/hazard_fwd.sv
`timescale 1ns/1ps
module hazard_fwd
  import hazard_pkg::*;
#(
  parameter int AW  = 5,
  parameter int NOP = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NOP*AW-1:0] exRs,
  input  logic [AW-1:0]   memRd,
  input  logic            memRegWrite,
  input  logic [AW-1:0]   wbRd,
  input  logic            wbRegWrite,
  output logic [NOP*2-1:0] selFlat
);
  for (genvar g = 0; g < NOP; g++) begin : gOp
    logic [AW-1:0] rs;
    logic          memHit, wbHit;
    fwdSel_e       sel;
    assign rs     = exRs[g*AW +: AW];
    assign memHit = memRegWrite && (memRd == rs) && (rs != '0);
    assign wbHit  = wbRegWrite  && (wbRd  == rs) && (rs != '0);
    always_comb begin
      if (memHit)     sel = FWD_MEM;
      else if (wbHit) sel = FWD_WB;
      else            sel = FWD_RF;
    end
    assign selFlat[g*2 +: 2] = sel;

    // R5
    no_x0_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
      (exRs[g*AW +: AW] == '0) |-> (selFlat[g*2 +: 2] == FWD_RF));
    // R4
    mem_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
      (memRegWrite && memRd == exRs[g*AW +: AW] && memRd != '0) |-> (selFlat[g*2 +: 2] == FWD_MEM));
  end
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] decRs1,
  input  logic [AW-1:0] decRs2,
  input  logic          decUseRs1,
  input  logic          decUseRs2,
  input  logic [AW-1:0] exRd,
  input  logic          exRegWrite,
  input  logic          exIsLoad,
  input  logic          branchTaken,
  output ctrlStrobes_t  strobes
);
  logic loadDest, useHit, loadUse;

  assign loadDest = exIsLoad && exRegWrite && (exRd != '0);
  assign useHit   = (decUseRs1 && decRs1 == exRd) || (decUseRs2 && decRs2 == exRd);
  assign loadUse  = loadDest && useHit && !branchTaken;

  always_comb begin
    strobes.holdFront = loadUse;
    strobes.bubbleEx  = loadUse || branchTaken;
    strobes.squashFd  = branchTaken;
  end

  // R6
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdFront |-> strobes.bubbleEx);
  // R8
  branch_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |-> (!strobes.holdFront && strobes.squashFd));
  // R7
  no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!exIsLoad || exRd == '0) |-> !strobes.holdFront);
endmodule

// File: rtl/hazard_datapath.sv
`timescale 1ns/1ps
module hazard_datapath
  import hazard_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [AW-1:0] decRs1,
  input  logic [AW-1:0] decRs2,
  input  logic [AW-1:0] exRs1,
  input  logic [AW-1:0] exRs2,
  input  logic [AW-1:0] memRd,
  input  logic          memRegWrite,
  input  logic [AW-1:0] wbRd,
  input  logic          wbRegWrite,
  input  logic [XLEN-1:0] wbData,
  output logic [XLEN-1:0] rdData1,
  output logic [XLEN-1:0] rdData2,
  output logic [1:0]    fwdSelA,
  output logic [1:0]    fwdSelB,
  output logic          pcWrEn,
  output logic          fdWrEn,
  output logic          fdFlush,
  output logic          dxFlush
);
  logic [2*XLEN-1:0] rdFlat;
  logic [3:0]        selFlat;

  hazard_regfile #(.XLEN(XLEN), .AW(AW), .NRD(2)) uRf (
    .clk(clk), .rstN(rstN),
    .wrEn(wbRegWrite), .wrAddr(wbRd), .wrData(wbData),
    .rdAddr({decRs2, decRs1}), .rdData(rdFlat)
  );

  hazard_fwd #(.AW(AW), .NOP(2)) uFwd (
    .clk(clk), .rstN(rstN),
    .exRs({exRs2, exRs1}),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .selFlat(selFlat)
  );

  assign rdData1 = rdFlat[XLEN-1:0];
  assign rdData2 = rdFlat[2*XLEN-1:XLEN];
  assign fwdSelA = selFlat[1:0];
  assign fwdSelB = selFlat[3:2];
  assign pcWrEn  = !strobes.holdFront;
  assign fdWrEn  = !strobes.holdFront;
  assign fdFlush = strobes.squashFd;
  assign dxFlush = strobes.bubbleEx;
endmodule

// File: rtl/hazard_unit.sv
`timescale 1ns/1ps
module hazard_unit
  import hazard_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   decRs1,
  input  logic [AW-1:0]   decRs2,
  input  logic            decUseRs1,
  input  logic            decUseRs2,
  input  logic [AW-1:0]   exRs1,
  input  logic [AW-1:0]   exRs2,
  input  logic [AW-1:0]   exRd,
  input  logic            exRegWrite,
  input  logic            exIsLoad,
  input  logic [AW-1:0]   memRd,
  input  logic            memRegWrite,
  input  logic [AW-1:0]   wbRd,
  input  logic            wbRegWrite,
  input  logic [XLEN-1:0] wbData,
  input  logic            branchTaken,
  output logic [XLEN-1:0] rdData1,
  output logic [XLEN-1:0] rdData2,
  output logic [1:0]      fwdSelA,
  output logic [1:0]      fwdSelB,
  output logic            pcWrEn,
  output logic            fdWrEn,
  output logic            fdFlush,
  output logic            dxFlush
);
  ctrlStrobes_t strobes;

  hazard_ctrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .decRs1(decRs1), .decRs2(decRs2),
    .decUseRs1(decUseRs1), .decUseRs2(decUseRs2),
    .exRd(exRd), .exRegWrite(exRegWrite), .exIsLoad(exIsLoad),
    .branchTaken(branchTaken), .strobes(strobes)
  );

  hazard_datapath #(.XLEN(XLEN), .AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .decRs1(decRs1), .decRs2(decRs2),
    .exRs1(exRs1), .exRs2(exRs2),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .wbRd(wbRd), .wbRegWrite(wbRegWrite), .wbData(wbData),
    .rdData1(rdData1), .rdData2(rdData2),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .pcWrEn(pcWrEn), .fdWrEn(fdWrEn),
    .fdFlush(fdFlush), .dxFlush(dxFlush)
  );
endmodule

// File: tb/hazard_unit_test.sv
`timescale 1ns/1ps
module hazard_unit_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [4:0]  decRs1 = 0, decRs2 = 0, exRs1 = 0, exRs2 = 0, exRd = 0, memRd = 0, wbRd = 0;
  logic        decUseRs1 = 0, decUseRs2 = 0, exRegWrite = 0, exIsLoad = 0;
  logic        memRegWrite = 0, wbRegWrite = 0, branchTaken = 0;
  logic [31:0] wbData = 0;
  logic [31:0] rdData1, rdData2;
  logic [1:0]  fwdSelA, fwdSelB;
  logic        pcWrEn, fdWrEn, fdFlush, dxFlush;

  int nChecks = 0;
  int nFails  = 0;
  int stallCount = 0;
  bit finished = 0;
  logic [31:0] model [32];

  always #2 clk = ~clk;

  hazard_unit uut (
    .clk(clk), .rstN(rstN),
    .decRs1(decRs1), .decRs2(decRs2), .decUseRs1(decUseRs1), .decUseRs2(decUseRs2),
    .exRs1(exRs1), .exRs2(exRs2), .exRd(exRd), .exRegWrite(exRegWrite), .exIsLoad(exIsLoad),
    .memRd(memRd), .memRegWrite(memRegWrite), .wbRd(wbRd), .wbRegWrite(wbRegWrite),
    .wbData(wbData), .branchTaken(branchTaken),
    .rdData1(rdData1), .rdData2(rdData2), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .pcWrEn(pcWrEn), .fdWrEn(fdWrEn), .fdFlush(fdFlush), .dxFlush(dxFlush)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(logic [4:0] a);
    if (a == 0) return 0;
    if (wbRegWrite && wbRd == a) return wbData;
    return model[a];
  endfunction

  function automatic string readTag(logic [4:0] a);
    if (a == 0) return "R1";
    if (wbRegWrite && wbRd == a) return "R2";
    return "R3";
  endfunction

  function automatic logic [1:0] expSel(logic [4:0] rs);
    if (rs == 0) return 2'b00;
    if (memRegWrite && memRd == rs) return 2'b01;
    if (wbRegWrite && wbRd == rs) return 2'b10;
    return 2'b00;
  endfunction

  // one cycle: compare every output against the model, then advance
  task automatic tick();
    bit stallExp;
    #1;
    check(readTag(decRs1), rdData1, expRead(decRs1));
    check(readTag(decRs2), rdData2, expRead(decRs2));
    check(exRs1 == 0 ? "R5" : "R4", {30'd0, fwdSelA}, {30'd0, expSel(exRs1)});
    check(exRs2 == 0 ? "R5" : "R4", {30'd0, fwdSelB}, {30'd0, expSel(exRs2)});
    stallExp = !branchTaken && exIsLoad && exRegWrite && exRd != 0 &&
               ((decUseRs1 && decRs1 == exRd) || (decUseRs2 && decRs2 == exRd));
    check(stallExp ? "R6" : "R7", {31'd0, pcWrEn}, {31'd0, !stallExp});
    check(stallExp ? "R6" : "R7", {31'd0, fdWrEn}, {31'd0, !stallExp});
    check("R8", {31'd0, fdFlush}, {31'd0, branchTaken});
    check(branchTaken ? "R8" : "R6", {31'd0, dxFlush}, {31'd0, branchTaken | stallExp});
    if (!pcWrEn) stallCount++;
    @(posedge clk);
    if (wbRegWrite && wbRd != 0) model[wbRd] = wbData;
    @(negedge clk);
  endtask

  task automatic idle();
    decUseRs1 = 0; decUseRs2 = 0; exRegWrite = 0; exIsLoad = 0;
    memRegWrite = 0; wbRegWrite = 0; branchTaken = 0;
    decRs1 = 0; decRs2 = 0; exRs1 = 0; exRs2 = 0; exRd = 0; memRd = 0; wbRd = 0;
  endtask

  task automatic wr(logic [4:0] r, logic [31:0] d);
    idle(); wbRd = r; wbData = d; wbRegWrite = 1; tick();
  endtask

  initial begin
    #100000;
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R9: reset state
    decRs1 = 5; decRs2 = 31; #1;
    check("R9", rdData1, 0); check("R9", rdData2, 0);
    check("R9", {30'd0, fwdSelA}, 0); check("R9", {31'd0, pcWrEn}, 1);
    check("R9", {31'd0, fdFlush}, 0);
    @(negedge clk);

    // R3: writes and retention; back-to-back writes to one register
    wr(3, 32'h0000_0AAA);
    wr(4, 32'h1234_5678);
    wr(7, 32'h1111_1111);
    wr(7, 32'h2222_2222);
    idle(); decRs1 = 3; decRs2 = 7; tick();
    check("R3", rdData2, 32'h2222_2222);

    // R2: same-cycle bypass on both ports
    idle(); decRs1 = 9; decRs2 = 9; wbRd = 9; wbRegWrite = 1; wbData = 32'hCAFE_F00D; tick();
    // R1: write to register 0 is invisible
    idle(); decRs1 = 0; decRs2 = 0; wbRd = 0; wbRegWrite = 1; wbData = 32'hFFFF_FFFF; tick();
    idle(); decRs1 = 0; tick();

    // R4: ALU chain, memory beats writeback; writeback alone; flag off
    idle(); exRs1 = 3; exRs2 = 4; memRd = 3; memRegWrite = 1; wbRd = 3; wbRegWrite = 1; wbData = 5; tick();
    idle(); exRs1 = 8; exRs2 = 4; memRd = 8; wbRd = 4; wbRegWrite = 1; wbData = 6; tick();
    // R5: x0 sources never forward
    idle(); exRs1 = 0; exRs2 = 0; memRd = 0; memRegWrite = 1; wbRd = 0; wbRegWrite = 1; tick();

    // R6: load-use pair walks through the pipe: one stall cycle
    stallCount = 0;
    idle(); decRs1 = 5; decRs2 = 6; decUseRs1 = 1; decUseRs2 = 1;
    exRd = 5; exRegWrite = 1; exIsLoad = 1; tick();          // load in execute
    idle(); decRs1 = 5; decRs2 = 6; decUseRs1 = 1; decUseRs2 = 1;
    memRd = 5; memRegWrite = 1; tick();                       // load in memory, bubble in execute
    idle(); exRs1 = 5; exRs2 = 6; wbRd = 5; wbRegWrite = 1; wbData = 32'hBEEF; tick();
    check("R6", stallCount, 1);

    // R7: unused source, x0 load target, non-load producer
    idle(); decRs2 = 5; decUseRs2 = 0; exRd = 5; exRegWrite = 1; exIsLoad = 1; tick();
    idle(); decRs1 = 0; decUseRs1 = 1; exRd = 0; exRegWrite = 1; exIsLoad = 1; tick();
    idle(); decRs1 = 5; decUseRs1 = 1; exRd = 5; exRegWrite = 1; tick();

    // R8: taken branch with pending load-use; not-taken branch
    idle(); decRs1 = 5; decUseRs1 = 1; exRd = 5; exRegWrite = 1; exIsLoad = 1; branchTaken = 1; tick();
    check("R8", {31'd0, pcWrEn}, 1);
    idle(); branchTaken = 0; tick();

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      decRs1 = 5'($urandom_range(0, 7)); decRs2 = 5'($urandom_range(0, 7));
      decUseRs1 = 1'($urandom); decUseRs2 = 1'($urandom);
      exRs1 = 5'($urandom_range(0, 7)); exRs2 = 5'($urandom_range(0, 7));
      exRd = 5'($urandom_range(0, 7)); exRegWrite = 1'($urandom); exIsLoad = 1'($urandom);
      memRd = 5'($urandom_range(0, 7)); memRegWrite = 1'($urandom);
      wbRd = 5'($urandom_range(0, 7)); wbRegWrite = 1'($urandom); wbData = $urandom;
      branchTaken = ($urandom_range(0, 7) == 0);
      tick();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule